// File: doc/BRIEF.md
# NAND Flash Controller Register Front End

This block is the register-facing side of a NAND flash controller. Software reaches it through a simple write-strobe and read-mux bus. It holds a control word, two timing words and a page count, all of which feed the controller. The control word carries a run bit, geometry and enable flags, and twelve interrupt mask bits. A set mask bit silences its source. The block also keeps a twelve-bit event status register. A downstream command sequencer sets its bits with single-cycle pulses, and software clears them by writing ones.

Commands reach the sequencer through a single entry address. Software sets run, and the block then raises its write-command request. Three successive writes to the entry address then fill command words 0, 1 and 2 in that order. The third write marks the command valid toward the sequencer, and the words stay held until the sequencer accepts them. A write made while a command is still waiting is dropped and recorded in a sticky overrun flag. Clearing run rewinds a partly entered command. An interrupt line, registered once, reports any status bit that is set and not masked.

Top module: `nfc_regfront`

## Requirements
- R1: After reset the control word reads 0x00000FFF, status reads 0, the interrupt output is low and no command is valid.
- R2: The control word (offset 0x00) stores only bits 31..26, 24, 18..16, 15, 14, 12 and 11..0, so it reads back as the written value ANDed with 0xFD07DFFF. Timing word 0 (0x04), timing word 1 (0x0C) and the page count (0x18) store and read back all 32 bits. The data buffer offset (0x40) reads zero.
- R3: A one on an `evt_set` bit sets that status bit at the next clock edge. Writing offset 0x14 clears each status bit whose write-data bit is one and leaves the bits written as zero. A set and a clear of the same bit in the same cycle leave the bit set.
- R4: `irq` is high one cycle after any status bit i is one while control bit i is zero. It is low one cycle after no such bit exists.
- R5: A control write that takes run (bit 28) from 0 to 1 sets status bit 0 (write-command request) at the same clock edge.
- R6: With run set and no command waiting, three writes to 0x48 load command words 0, 1 and 2 in order. Word n appears on `cmd_words[32n+31:32n]` and reads back at 0x48 + 4n. `cmd_valid` rises at the edge of the third write and holds the words stable until accepted.
- R7: Writes to 0x48 while run is 0 are ignored: no word changes and no entry progress is kept.
- R8: Clearing run discards a partly entered command, so the next entry after run is set again starts at word 0.
- R9: A write to 0x48 while `cmd_valid` is high is ignored and sets a sticky overrun flag. The flag reads at status bit 12 and is cleared by writing one to bit 12 of 0x14.
- R10: `cmd_ready` high while `cmd_valid` is high clears `cmd_valid` at that edge. If run is set, the same edge sets status bit 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_set | input | 12 | Status set pulses from the sequencer |
| cmd_ready | input | 1 | Sequencer accepts the waiting command |
| cmd_valid | output | 1 | A complete three-word command is waiting |
| cmd_words | output | 96 | Command words 2..0, word 0 in the low 32 bits |
| ctrl_word | output | 32 | Current control word |
| timing0 | output | 32 | Timing word 0 |
| timing1 | output | 32 | Timing word 1 |
| page_count | output | 32 | Page count word |
| irq | output | 1 | Registered interrupt request |

## Verification
The interrupt path is driven by a table of mask and event pairs. The table covers a fully masked source, a fully open one, a single unmasked bit against a masked neighbour, and a group of events lying entirely under a group of mask bits. These cases show that the inverted mask polarity and the per-bit alignment are right. Command entry is tried with run low, a normal three-word entry, a fourth write into a waiting command, and an entry cut short by clearing run. Comparing word contents and order after each case tells a dropped write from a shifted pointer. Directed cases cover reset values, the control write mask, a status set and clear in the same cycle, and the write-command request after run rises and after acceptance.

// File: rtl/nfc_regs_pkg.sv
`timescale 1ns/1ps
// Package: byte offsets, control-word layout and status bit positions shared
// by the register front end, its checker and its bench.
package nfc_regs_pkg;
    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_TIM0  = 8'h04;
    localparam logic [7:0] A_TIM1  = 8'h0C;
    localparam logic [7:0] A_STAT  = 8'h14;
    localparam logic [7:0] A_PGCNT = 8'h18;
    localparam logic [7:0] A_DBUF  = 8'h40;
    localparam logic [7:0] A_CMD0  = 8'h48;

    localparam logic [31:0] CTRL_WMASK = 32'hFD07_DFFF;
    localparam logic [31:0] CTRL_RST   = 32'h0000_0FFF;
    localparam int          RUN_BIT    = 28;
    localparam int          ST_CMDREQ  = 0;
endpackage

// File: rtl/nfc_ctrl_regs.sv
`timescale 1ns/1ps
// Module: nfc_ctrl_regs
// Holds the control word, with its write mask and reset value, and a
// generated set of plain read/write words (timing words, page count).
// Assumes one write strobe per register, decoded by the parent.
module nfc_ctrl_regs
    import nfc_regs_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_PLAIN = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_ctrl,
    input  logic [NUM_PLAIN-1:0]        wr_plain,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           ctrl_q,
    output logic [NUM_PLAIN*DATA_W-1:0] plain_q
);
    localparam logic [DATA_W-1:0] WMASK = DATA_W'(CTRL_WMASK);
    localparam logic [DATA_W-1:0] RSTV  = DATA_W'(CTRL_RST);

    // Control word: masked write, reset to all interrupt sources masked.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= RSTV;
        else if (wr_ctrl) ctrl_q <= wdata & WMASK;
    end

    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
        // Plain word g: full-width storage.
        always_ff @(posedge clk) begin
            if (!rst_n)           plain_q[g*DATA_W +: DATA_W] <= '0;
            else if (wr_plain[g]) plain_q[g*DATA_W +: DATA_W] <= wdata;
        end
    end
endmodule

// File: rtl/nfc_status_regs.sv
`timescale 1ns/1ps
// Module: nfc_status_regs
// Event status bits, set by pulses and cleared by write-one; a set beats a
// clear in the same cycle. Drives a registered interrupt from the unmasked
// bits (mask bit one = source disabled).
module nfc_status_regs #(
    parameter int STAT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] clr_vec,
    input  logic [STAT_W-1:0] mask,
    output logic [STAT_W-1:0] stat_q,
    output logic              irq_q
);
    // Status update: clear requested bits, then apply new events.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | set_vec;
    end

    // Interrupt: one register after the unmasked-bit reduction.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat_q & ~mask);
    end
endmodule

// File: rtl/nfc_cmd_entry.sv
`timescale 1ns/1ps
// Module: nfc_cmd_entry
// Collects CMD_WORDS successive writes to one address into command words,
// then holds them valid until the sequencer accepts. Entries count only
// while run is high; run low rewinds the pointer. Writes into a waiting
// command are dropped and raise a sticky overrun flag.
module nfc_cmd_entry #(
    parameter int DATA_W    = 32,
    parameter int CMD_WORDS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic                        wr_cmd,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        seq_ready,
    input  logic                        ovr_clr,
    output logic [CMD_WORDS*DATA_W-1:0] words_q,
    output logic                        valid_q,
    output logic [((CMD_WORDS>1)?$clog2(CMD_WORDS):1)-1:0] ptr_q,
    output logic                        ovr_q
);
    localparam int PTR_W = (CMD_WORDS > 1) ? $clog2(CMD_WORDS) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(CMD_WORDS - 1);

    logic load;
    assign load = run && wr_cmd && !valid_q;

    // Entry pointer and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            if (valid_q && seq_ready) valid_q <= 1'b0;
            if (!run) begin
                ptr_q <= '0;
            end else if (load) begin
                if (ptr_q == LAST) begin
                    ptr_q   <= '0;
                    valid_q <= 1'b1;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
        end
    end

    // Sticky overrun: a write into a waiting command; set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovr_q <= 1'b0;
        else if (run && wr_cmd && valid_q)   ovr_q <= 1'b1;
        else if (ovr_clr)                    ovr_q <= 1'b0;
    end

    for (genvar g = 0; g < CMD_WORDS; g++) begin : g_word
        // Command word g: loaded when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words_q[g*DATA_W +: DATA_W] <= '0;
            else if (load && ptr_q == PTR_W'(g))
                words_q[g*DATA_W +: DATA_W] <= wdata;
        end
    end
endmodule

// File: rtl/nfc_regfront.sv
`timescale 1ns/1ps
// Module: nfc_regfront
// Register front end of a NAND controller: decodes register writes, muxes
// reads, and links the control, status and command-entry pieces. Assumes
// single-cycle writes and a read bus that samples reg_rdata combinationally.
module nfc_regfront
    import nfc_regs_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int STAT_W    = 12,
    parameter int CMD_WORDS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic [STAT_W-1:0]           evt_set,
    input  logic                        cmd_ready,
    output logic                        cmd_valid,
    output logic [CMD_WORDS*DATA_W-1:0] cmd_words,
    output logic [DATA_W-1:0]           ctrl_word,
    output logic [DATA_W-1:0]           timing0,
    output logic [DATA_W-1:0]           timing1,
    output logic [DATA_W-1:0]           page_count,
    output logic                        irq
);
    localparam int NUM_PLAIN = 3;
    localparam int PTR_W     = (CMD_WORDS > 1) ? $clog2(CMD_WORDS) : 1;

    logic                        wr_ctrl, wr_stat, wr_cmd;
    logic [NUM_PLAIN-1:0]        wr_plain;
    logic [DATA_W-1:0]           ctrl_q;
    logic [NUM_PLAIN*DATA_W-1:0] plain_q;
    logic [STAT_W-1:0]           stat, set_vec, clr_vec;
    logic                        run, run_rise, accept, ovr;
    logic [PTR_W-1:0]            entry_ptr;

    // Write decode.
    always_comb begin
        wr_ctrl     = reg_we && reg_addr == ADDR_W'(A_CTRL);
        wr_stat     = reg_we && reg_addr == ADDR_W'(A_STAT);
        wr_cmd      = reg_we && reg_addr == ADDR_W'(A_CMD0);
        wr_plain[0] = reg_we && reg_addr == ADDR_W'(A_TIM0);
        wr_plain[1] = reg_we && reg_addr == ADDR_W'(A_TIM1);
        wr_plain[2] = reg_we && reg_addr == ADDR_W'(A_PGCNT);
    end

    assign run      = ctrl_q[RUN_BIT];
    assign run_rise = wr_ctrl && reg_wdata[RUN_BIT] && !run;
    assign accept   = cmd_valid && cmd_ready;

    // Status set sources: sequencer pulses plus the command request.
    always_comb begin
        set_vec            = evt_set;
        set_vec[ST_CMDREQ] = evt_set[ST_CMDREQ] | run_rise | (accept && run);
        clr_vec            = wr_stat ? reg_wdata[STAT_W-1:0] : '0;
    end

    nfc_ctrl_regs #(.DATA_W(DATA_W), .NUM_PLAIN(NUM_PLAIN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_plain(wr_plain),
        .wdata(reg_wdata), .ctrl_q(ctrl_q), .plain_q(plain_q)
    );

    nfc_status_regs #(.STAT_W(STAT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .mask(ctrl_q[STAT_W-1:0]), .stat_q(stat), .irq_q(irq)
    );

    nfc_cmd_entry #(.DATA_W(DATA_W), .CMD_WORDS(CMD_WORDS)) u_entry (
        .clk(clk), .rst_n(rst_n), .run(run), .wr_cmd(wr_cmd),
        .wdata(reg_wdata), .seq_ready(cmd_ready),
        .ovr_clr(wr_stat && reg_wdata[STAT_W]),
        .words_q(cmd_words), .valid_q(cmd_valid), .ptr_q(entry_ptr), .ovr_q(ovr)
    );

    assign ctrl_word  = ctrl_q;
    assign timing0    = plain_q[0*DATA_W +: DATA_W];
    assign timing1    = plain_q[1*DATA_W +: DATA_W];
    assign page_count = plain_q[2*DATA_W +: DATA_W];

    // Read mux; unmapped offsets, including the data buffer, read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL))  reg_rdata = ctrl_q;
        if (reg_addr == ADDR_W'(A_TIM0))  reg_rdata = timing0;
        if (reg_addr == ADDR_W'(A_TIM1))  reg_rdata = timing1;
        if (reg_addr == ADDR_W'(A_PGCNT)) reg_rdata = page_count;
        if (reg_addr == ADDR_W'(A_STAT))  reg_rdata = DATA_W'({ovr, stat});
        for (int i = 0; i < CMD_WORDS; i++)
            if (reg_addr == ADDR_W'(A_CMD0) + ADDR_W'(4 * i))
                reg_rdata = cmd_words[i*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/nfc_regfront_chk.sv
`timescale 1ns/1ps
// Module: nfc_regfront_chk
// Property checker for nfc_regfront, attached by bind below.
module nfc_regfront_chk
    import nfc_regs_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int STAT_W    = 12,
    parameter int CMD_WORDS = 3,
    parameter int PTR_W     = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_we,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [DATA_W-1:0]           reg_wdata,
    input logic [STAT_W-1:0]           evt_set,
    input logic                        cmd_ready,
    input logic                        cmd_valid,
    input logic [CMD_WORDS*DATA_W-1:0] cmd_words,
    input logic [DATA_W-1:0]           ctrl_q,
    input logic [STAT_W-1:0]           stat,
    input logic                        ovr,
    input logic [PTR_W-1:0]            entry_ptr,
    input logic                        irq
);
    logic stat_wr;
    assign stat_wr = reg_we && reg_addr == ADDR_W'(A_STAT);

    p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((stat & $past(evt_set)) == $past(evt_set)));

    p_irq_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~ctrl_q[STAT_W-1:0]) != '0) |=> irq);

    p_irq_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~ctrl_q[STAT_W-1:0]) == '0) |=> !irq);

    p_run_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(A_CTRL) && reg_wdata[RUN_BIT]
         && !ctrl_q[RUN_BIT]) |=> stat[ST_CMDREQ]);

    p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_words)));

    p_ptr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[RUN_BIT] |=> (entry_ptr == '0));

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(stat_wr && reg_wdata[STAT_W])) |=> ovr);

    p_accept_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_valid);
endmodule

bind nfc_regfront nfc_regfront_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W),
    .CMD_WORDS(CMD_WORDS), .PTR_W(PTR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt_set(evt_set), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_words(cmd_words), .ctrl_q(ctrl_q),
    .stat(stat), .ovr(ovr), .entry_ptr(entry_ptr), .irq(irq)
);

// File: tb/nfc_regfront_bench.sv
`timescale 1ns/1ps
// Bench for nfc_regfront: vector table for status/interrupt, then directed
// tests for reset, control mask, command entry and corner cases.
module nfc_regfront_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] evt_set = '0;
    logic        cmd_ready = 1'b0;
    logic        cmd_valid;
    logic [95:0] cmd_words;
    logic [31:0] ctrl_word, timing0, timing1, page_count;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    nfc_regfront u_nfc_regfront (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
        .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_words(cmd_words),
        .ctrl_word(ctrl_word), .timing0(timing0), .timing1(timing1),
        .page_count(page_count), .irq(irq)
    );

    // {mask[11:0], event[11:0]}
    localparam logic [23:0] VEC [6] = '{
        {12'hFFF, 12'h800}, {12'h000, 12'h800}, {12'hFF7, 12'h008},
        {12'hFF7, 12'h010}, {12'h0F0, 12'h00F}, {12'h0F0, 12'h0F0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_evt(input logic [11:0] e);
        @(negedge clk);
        evt_set = e;
        @(negedge clk);
        evt_set = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdreg(8'h00, rd); chk("R1 ctrl reset", rd, 32'h0000_0FFF);
        rdreg(8'h14, rd); chk("R1 status reset", rd, 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
        chk("R1 valid reset", {31'b0, cmd_valid}, 32'h0);

        // R3/R4 table: mask polarity and bit alignment
        for (int i = 0; i < 6; i++) begin
            logic [11:0] m, e;
            m = VEC[i][23:12]; e = VEC[i][11:0];
            wr(8'h14, 32'h1FFF);
            wr(8'h00, {20'b0, m});
            pulse_evt(e);
            rdreg(8'h14, rd); chk("R3 status after event", rd, {20'b0, e});
            @(negedge clk);
            chk("R4 irq from table", {31'b0, irq}, {31'b0, |(e & ~m)});
        end
        wr(8'h14, 32'h1FFF);
        @(negedge clk); @(negedge clk);
        chk("R4 irq drops after clear", {31'b0, irq}, 32'h0);

        // R3 write-zero keeps, write-one clears, set beats clear
        pulse_evt(12'h0A0);
        wr(8'h14, 32'h020);
        rdreg(8'h14, rd); chk("R3 partial clear", rd, 32'h080);
        wr(8'h14, 32'h1FFF);
        @(negedge clk);
        evt_set = 12'h008; reg_we = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h008;
        @(negedge clk);
        evt_set = '0; reg_we = 1'b0;
        rdreg(8'h14, rd); chk("R3 set wins over clear", rd, 32'h008);

        // R2 control mask, plain words, data buffer reads zero
        wr(8'h00, 32'hFFFF_FFFF);
        rdreg(8'h00, rd); chk("R2 ctrl write mask", rd, 32'hFD07_DFFF);
        wr(8'h00, 32'h0000_0FFF);
        wr(8'h04, 32'hA5A5_0001); wr(8'h0C, 32'h5A5A_0002); wr(8'h18, 32'hDEAD_BEEF);
        rdreg(8'h04, rd); chk("R2 timing0", rd, 32'hA5A5_0001);
        rdreg(8'h0C, rd); chk("R2 timing1", rd, 32'h5A5A_0002);
        rdreg(8'h18, rd); chk("R2 page count", rd, 32'hDEAD_BEEF);
        rdreg(8'h40, rd); chk("R2 data buffer zero", rd, 32'h0);
        wr(8'h14, 32'h1FFF);

        // R7 entry ignored with run low
        wr(8'h48, 32'h1111_1111); wr(8'h48, 32'h2222_2222); wr(8'h48, 32'h3333_3333);
        chk("R7 no valid with run low", {31'b0, cmd_valid}, 32'h0);
        rdreg(8'h48, rd); chk("R7 word0 untouched", rd, 32'h0);

        // R5 run rise raises command request
        wr(8'h00, 32'h1000_0FFF);
        rdreg(8'h14, rd); chk("R5 request after run", rd, 32'h001);

        // R6 three-word entry
        wr(8'h48, 32'hAAAA_0000);
        chk("R6 not valid after one word", {31'b0, cmd_valid}, 32'h0);
        wr(8'h48, 32'hBBBB_1111); wr(8'h48, 32'hCCCC_2222);
        chk("R6 valid after third", {31'b0, cmd_valid}, 32'h1);
        chk("R6 word0", cmd_words[31:0], 32'hAAAA_0000);
        chk("R6 word1", cmd_words[63:32], 32'hBBBB_1111);
        chk("R6 word2", cmd_words[95:64], 32'hCCCC_2222);
        rdreg(8'h4C, rd); chk("R6 word1 readback", rd, 32'hBBBB_1111);

        // R9 overrun
        wr(8'h48, 32'hDDDD_3333);
        chk("R9 word0 kept", cmd_words[31:0], 32'hAAAA_0000);
        chk("R9 word2 kept", cmd_words[95:64], 32'hCCCC_2222);
        rdreg(8'h14, rd); chk("R9 overrun flag", {31'b0, rd[12]}, 32'h1);
        wr(8'h14, 32'h1000);
        rdreg(8'h14, rd); chk("R9 overrun cleared", {31'b0, rd[12]}, 32'h0);

        // R10 acceptance
        wr(8'h14, 32'h1FFF);
        @(negedge clk); cmd_ready = 1'b1;
        @(negedge clk); cmd_ready = 1'b0;
        chk("R10 valid drops", {31'b0, cmd_valid}, 32'h0);
        rdreg(8'h14, rd); chk("R10 request re-raised", rd, 32'h001);

        // R8 run clear rewinds partial entry
        wr(8'h48, 32'hEEEE_0000);
        wr(8'h00, 32'h0000_0FFF);
        wr(8'h00, 32'h1000_0FFF);
        wr(8'h48, 32'h0F0F_0001); wr(8'h48, 32'h0F0F_0002);
        chk("R8 not valid after two", {31'b0, cmd_valid}, 32'h0);
        wr(8'h48, 32'h0F0F_0003);
        chk("R8 valid", {31'b0, cmd_valid}, 32'h1);
        chk("R8 word0 restarts", cmd_words[31:0], 32'h0F0F_0001);
        chk("R8 word2", cmd_words[95:64], 32'h0F0F_0003);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule